// File: doc/BRIEF.md
# Framed Tap Statistics Monitor

This block observes a single event tap and condenses what it sees into one summary record per frame. The tap is either the valid/ready handshake of a dataflow edge, where each completed transfer contributes one sample, or the occupancy level of an input queue, where every cycle contributes one sample. In both cases the sample value is taken from a value input. Samples are only admitted while a qualifying context holds. The context is any Boolean function (built from AND, OR and NOT) of three other tap signals, stored as an 8-entry truth table. A typical context is "upstream is not starved and downstream is not stalled".

Frames are a run-time programmable number of clock cycles long. When a frame closes, the block captures one record and offers it on a valid/ready output. The record holds a frame sequence number and the length the frame actually used. It carries one selected metric: count, minimum, maximum or sum, so a mean can be formed downstream. It also carries a saturating sum of squares for variance, an 8-bin histogram with power-of-two bin edges, and an outlier count and flag. A record that is still pending when the next frame closes is replaced, and an overrun counter advances.

Top module: `tap_frame_monitor`

## Requirements
- R1: During and directly after reset, `rec_valid` is 0 and `overrun_cnt` is 0. The first frame is as long as the `frame_len` value present while reset was asserted.
- R2: A sample is admitted only in cycles where bit `ctx_taps` of `ctx_table` is 1. The bit index is ctx_taps[2]*4 + ctx_taps[1]*2 + ctx_taps[0].
- R3: With `tap_mode` = 0 (edge), a sample is taken in cycles with `tap_valid` and `tap_ready` both 1. With `tap_mode` = 1 (level), a sample is taken in every cycle. In both modes, the sample value is `tap_value` and the R2 context still applies.
- R4: A frame spans the number of cycles in `frame_len`, with 0 treated as 1. A new `frame_len` takes effect only from the next frame boundary. `rec_len` reports the length the frame used.
- R5: A record becomes valid in the cycle after the last cycle of its frame, and that last cycle's sample is included. `rec_seq` is 0 for the first frame and rises by one for each frame that closes.
- R6: `metric_sel`, as sampled in a frame's last cycle, selects `rec_metric`: 0 = sample count, 1 = minimum, 2 = maximum, 3 = sum. A frame with no samples reports a minimum of all ones and a maximum of 0.
- R7: The sum and the sum of squares (`rec_sumsq`) saturate at all ones instead of wrapping.
- R8: `rec_hist` bin k sits at bits [8k+7:8k]. With b = `hist_base`: bin 0 counts values below 2^b, bin k for 1 ≤ k ≤ 6 counts values in [2^(b+k-1), 2^(b+k)), and bin 7 counts values from 2^(b+6) upward. All bins start empty in each frame.
- R9: `rec_outliers` counts the frame's samples strictly greater than `outlier_thr`. `rec_outlier_flag` is 1 exactly when that count is nonzero.
- R10: While `rec_valid` is 1 and `rec_ready` is 0, the record stays unchanged until the next frame closes. At that point the new record replaces it and `overrun_cnt` increments by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_mode | input | 1 | 0 = edge transfers, 1 = queue level every cycle |
| tap_valid | input | 1 | Edge handshake valid |
| tap_ready | input | 1 | Edge handshake ready |
| tap_value | input | VAL_W | Sample value (transfer measure or occupancy) |
| ctx_taps | input | 3 | Other taps feeding the context |
| ctx_table | input | 8 | Context truth table indexed by ctx_taps |
| frame_len | input | FLEN_W | Frame length in cycles, 0 means 1 |
| metric_sel | input | 2 | Metric select for the record |
| hist_base | input | 3 | Histogram base exponent |
| outlier_thr | input | VAL_W | Outlier threshold |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record accepted by consumer |
| rec_seq | output | SEQ_W | Frame sequence number |
| rec_len | output | FLEN_W | Frame length used |
| rec_metric | output | SUM_W | Selected metric |
| rec_sumsq | output | SQ_W | Saturating sum of squares |
| rec_hist | output | 8*HB_W | Histogram bins, bin 0 in the low bits |
| rec_outliers | output | FLEN_W | Outlier count |
| rec_outlier_flag | output | 1 | Outlier seen in frame |
| overrun_cnt | output | OVR_W | Saturating count of replaced records |

## Verification
The hardest situation to reach is a record being replaced. This needs the consumer to stay silent across a whole frame boundary while an earlier record is still pending, without also swallowing the record before it. The stimulus lets one record be taken, drops `rec_ready` in the second cycle of the next frame, and holds it low through two closings. It then raises `rec_ready` just as the replacing record appears, and checks that the first pending record stayed put and that the sequence gap matches the overrun count. Saturation is reached by building the bench instance with narrow sum and square widths and feeding all-ones samples.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

    localparam int NBINS    = 8;
    localparam int CTX_W    = 3;
    localparam int CTX_TT_W = 1 << CTX_W;
    localparam int BASE_W   = 3;

    typedef enum logic [1:0] {
        MET_COUNT = 2'd0,
        MET_MIN   = 2'd1,
        MET_MAX   = 2'd2,
        MET_SUM   = 2'd3
    } metric_e;

    typedef enum logic {
        TAP_EDGE  = 1'b0,
        TAP_LEVEL = 1'b1
    } tap_mode_e;

    // Any Boolean function of the context taps, given as a truth table.
    function automatic logic ctx_eval(input logic [CTX_TT_W-1:0] table_bits,
                                      input logic [CTX_W-1:0]    taps);
        return table_bits[taps];
    endfunction

endpackage

// File: rtl/tfm_frame_timer.sv
module tfm_frame_timer #(
    parameter int FLEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLEN_W-1:0] frame_len,
    output logic              frame_last,
    output logic [FLEN_W-1:0] len_used
);

    logic [FLEN_W-1:0] cyc_q;
    logic [FLEN_W-1:0] len_eff;

    assign len_eff    = (frame_len == '0) ? FLEN_W'(1) : frame_len;
    assign frame_last = (cyc_q == len_used - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q    <= '0;
            len_used <= len_eff;
        end else if (frame_last) begin
            cyc_q    <= '0;
            len_used <= len_eff;
        end else begin
            cyc_q    <= cyc_q + 1'b1;
        end
    end

    // R4
    cyc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_q < len_used);

    // R4
    len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(len_used));

endmodule

// File: rtl/tfm_stats_accum.sv
module tfm_stats_accum #(
    parameter int VAL_W  = 8,
    parameter int FLEN_W = 16,
    parameter int SUM_W  = 32,
    parameter int SQ_W   = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  logic [VAL_W-1:0]  smp_val,
    input  logic [VAL_W-1:0]  thr,
    input  logic              clear,
    output logic [FLEN_W-1:0] cnt_nx,
    output logic [VAL_W-1:0]  min_nx,
    output logic [VAL_W-1:0]  max_nx,
    output logic [SUM_W-1:0]  sum_nx,
    output logic [SQ_W-1:0]   sq_nx,
    output logic [FLEN_W-1:0] outl_nx
);

    localparam int SQR_W = 2 * VAL_W;

    logic [FLEN_W-1:0] cnt_q, outl_q;
    logic [VAL_W-1:0]  min_q, max_q;
    logic [SUM_W-1:0]  sum_q;
    logic [SQ_W-1:0]   sq_q;

    logic [SQR_W-1:0]  sqr;
    logic [SUM_W:0]    sum_wide;
    logic [SQ_W:0]     sq_wide;

    assign sqr      = SQR_W'(smp_val) * SQR_W'(smp_val);
    assign sum_wide = {1'b0, sum_q} + (SUM_W+1)'(smp_val);
    assign sq_wide  = {1'b0, sq_q} + (SQ_W+1)'(sqr);

    always_comb begin
        cnt_nx  = cnt_q;
        min_nx  = min_q;
        max_nx  = max_q;
        sum_nx  = sum_q;
        sq_nx   = sq_q;
        outl_nx = outl_q;
        if (smp_en) begin
            cnt_nx  = cnt_q + 1'b1;
            min_nx  = (smp_val < min_q) ? smp_val : min_q;
            max_nx  = (smp_val > max_q) ? smp_val : max_q;
            sum_nx  = sum_wide[SUM_W] ? '1 : sum_wide[SUM_W-1:0];
            sq_nx   = sq_wide[SQ_W]   ? '1 : sq_wide[SQ_W-1:0];
            outl_nx = outl_q + FLEN_W'(smp_val > thr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            min_q  <= '1;
            max_q  <= '0;
            sum_q  <= '0;
            sq_q   <= '0;
            outl_q <= '0;
        end else begin
            cnt_q  <= cnt_nx;
            min_q  <= min_nx;
            max_q  <= max_nx;
            sum_q  <= sum_nx;
            sq_q   <= sq_nx;
            outl_q <= outl_nx;
        end
    end

    // R6
    min_max_order_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> (min_q <= max_q));

    // R7
    sum_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (sum_q >= $past(sum_q)));

    // R7
    sq_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (sq_q >= $past(sq_q)));

    // R9
    outl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        outl_q <= cnt_q);

endmodule

// File: rtl/tfm_histogram.sv
module tfm_histogram
    import tfm_pkg::*;
#(
    parameter int VAL_W = 8,
    parameter int HB_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_en,
    input  logic [VAL_W-1:0]      smp_val,
    input  logic [BASE_W-1:0]     base,
    input  logic                  clear,
    output logic [NBINS*HB_W-1:0] bins_nx
);

    logic [NBINS-1:0] hit;
    logic [31:0]      v32;
    logic [31:0]      b32;

    assign v32 = 32'(smp_val);
    assign b32 = 32'(base);

    for (genvar k = 0; k < NBINS; k++) begin : g_bin
        logic [31:0]     lo_edge;
        logic [31:0]     hi_edge;
        logic            above_lo;
        logic            below_hi;
        logic [HB_W-1:0] bin_q;
        logic [HB_W-1:0] bin_nx;

        if (k == 0) begin : g_first
            assign lo_edge  = '0;
            assign above_lo = 1'b1;
        end else begin : g_rest
            assign lo_edge  = 32'd1 << (b32 + 32'(k - 1));
            assign above_lo = (v32 >= lo_edge);
        end

        if (k == NBINS - 1) begin : g_top
            assign hi_edge  = '1;
            assign below_hi = 1'b1;
        end else begin : g_mid
            assign hi_edge  = 32'd1 << (b32 + 32'(k));
            assign below_hi = (v32 < hi_edge);
        end

        assign hit[k]  = smp_en && above_lo && below_hi;
        assign bin_nx  = (hit[k] && (bin_q != '1)) ? bin_q + 1'b1 : bin_q;
        assign bins_nx[k*HB_W +: HB_W] = bin_nx;

        always_ff @(posedge clk) begin
            if (rst || clear) bin_q <= '0;
            else              bin_q <= bin_nx;
        end
    end

    // R8
    one_bin_chk: assert property (@(posedge clk) disable iff (rst)
        smp_en |-> ($countones(hit) == 1));

    // R8
    idle_bins_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_en |-> (hit == '0));

endmodule

// File: rtl/tfm_record_out.sv
module tfm_record_out
    import tfm_pkg::*;
#(
    parameter int VAL_W  = 8,
    parameter int FLEN_W = 16,
    parameter int SUM_W  = 32,
    parameter int SQ_W   = 40,
    parameter int HB_W   = 8,
    parameter int SEQ_W  = 8,
    parameter int OVR_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [1:0]            metric_sel,
    input  logic [FLEN_W-1:0]     cnt_in,
    input  logic [VAL_W-1:0]      min_in,
    input  logic [VAL_W-1:0]      max_in,
    input  logic [SUM_W-1:0]      sum_in,
    input  logic [SQ_W-1:0]       sq_in,
    input  logic [FLEN_W-1:0]     len_in,
    input  logic [NBINS*HB_W-1:0] hist_in,
    input  logic [FLEN_W-1:0]     outl_in,
    input  logic                  rec_ready,
    output logic                  rec_valid,
    output logic [SEQ_W-1:0]      rec_seq,
    output logic [FLEN_W-1:0]     rec_len,
    output logic [SUM_W-1:0]      rec_metric,
    output logic [SQ_W-1:0]       rec_sumsq,
    output logic [NBINS*HB_W-1:0] rec_hist,
    output logic [FLEN_W-1:0]     rec_outliers,
    output logic                  rec_outlier_flag,
    output logic [OVR_W-1:0]      overrun_cnt
);

    logic [SEQ_W-1:0] seq_ctr;
    logic [SUM_W-1:0] met_sel;
    logic             replacing;

    always_comb begin
        case (metric_e'(metric_sel))
            MET_COUNT: met_sel = SUM_W'(cnt_in);
            MET_MIN:   met_sel = SUM_W'(min_in);
            MET_MAX:   met_sel = SUM_W'(max_in);
            default:   met_sel = sum_in;
        endcase
    end

    assign replacing = load && rec_valid && !rec_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid        <= 1'b0;
            seq_ctr          <= '0;
            rec_seq          <= '0;
            rec_len          <= '0;
            rec_metric       <= '0;
            rec_sumsq        <= '0;
            rec_hist         <= '0;
            rec_outliers     <= '0;
            rec_outlier_flag <= 1'b0;
            overrun_cnt      <= '0;
        end else begin
            if (load) begin
                rec_valid        <= 1'b1;
                rec_seq          <= seq_ctr;
                seq_ctr          <= seq_ctr + 1'b1;
                rec_len          <= len_in;
                rec_metric       <= met_sel;
                rec_sumsq        <= sq_in;
                rec_hist         <= hist_in;
                rec_outliers     <= outl_in;
                rec_outlier_flag <= (outl_in != '0);
                if (replacing && (overrun_cnt != '1))
                    overrun_cnt <= overrun_cnt + 1'b1;
            end else if (rec_valid && rec_ready) begin
                rec_valid <= 1'b0;
            end
        end
    end

    // R5
    load_valid_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> rec_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready && !load) |=>
            (rec_valid && $stable(rec_seq) && $stable(rec_metric) && $stable(rec_hist)));

    // R10
    overrun_step_chk: assert property (@(posedge clk) disable iff (rst)
        (load && rec_valid && !rec_ready && (overrun_cnt != '1)) |=>
            (overrun_cnt == $past(overrun_cnt) + 1'b1));

    // R10
    overrun_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && rec_valid && !rec_ready) |=> $stable(overrun_cnt));

endmodule

// File: rtl/tap_frame_monitor.sv
module tap_frame_monitor
    import tfm_pkg::*;
#(
    parameter int VAL_W  = 8,
    parameter int FLEN_W = 16,
    parameter int SUM_W  = 32,
    parameter int SQ_W   = 40,
    parameter int HB_W   = 8,
    parameter int SEQ_W  = 8,
    parameter int OVR_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tap_mode,
    input  logic                  tap_valid,
    input  logic                  tap_ready,
    input  logic [VAL_W-1:0]      tap_value,
    input  logic [2:0]            ctx_taps,
    input  logic [7:0]            ctx_table,
    input  logic [FLEN_W-1:0]     frame_len,
    input  logic [1:0]            metric_sel,
    input  logic [2:0]            hist_base,
    input  logic [VAL_W-1:0]      outlier_thr,
    output logic                  rec_valid,
    input  logic                  rec_ready,
    output logic [SEQ_W-1:0]      rec_seq,
    output logic [FLEN_W-1:0]     rec_len,
    output logic [SUM_W-1:0]      rec_metric,
    output logic [SQ_W-1:0]       rec_sumsq,
    output logic [8*HB_W-1:0]     rec_hist,
    output logic [FLEN_W-1:0]     rec_outliers,
    output logic                  rec_outlier_flag,
    output logic [OVR_W-1:0]      overrun_cnt
);

    logic              ctx_ok;
    logic              tap_fire;
    logic              smp_en;
    logic              frame_last;
    logic [FLEN_W-1:0] len_used;

    logic [FLEN_W-1:0] cnt_nx, outl_nx;
    logic [VAL_W-1:0]  min_nx, max_nx;
    logic [SUM_W-1:0]  sum_nx;
    logic [SQ_W-1:0]   sq_nx;
    logic [NBINS*HB_W-1:0] bins_nx;

    assign ctx_ok   = ctx_eval(ctx_table, ctx_taps);
    assign tap_fire = (tap_mode_e'(tap_mode) == TAP_LEVEL) || (tap_valid && tap_ready);
    assign smp_en   = ctx_ok && tap_fire;

    tfm_frame_timer #(.FLEN_W(FLEN_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_len  (frame_len),
        .frame_last (frame_last),
        .len_used   (len_used)
    );

    tfm_stats_accum #(
        .VAL_W(VAL_W), .FLEN_W(FLEN_W), .SUM_W(SUM_W), .SQ_W(SQ_W)
    ) u_stats (
        .clk     (clk),
        .rst     (rst),
        .smp_en  (smp_en),
        .smp_val (tap_value),
        .thr     (outlier_thr),
        .clear   (frame_last),
        .cnt_nx  (cnt_nx),
        .min_nx  (min_nx),
        .max_nx  (max_nx),
        .sum_nx  (sum_nx),
        .sq_nx   (sq_nx),
        .outl_nx (outl_nx)
    );

    tfm_histogram #(.VAL_W(VAL_W), .HB_W(HB_W)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .smp_en  (smp_en),
        .smp_val (tap_value),
        .base    (hist_base),
        .clear   (frame_last),
        .bins_nx (bins_nx)
    );

    tfm_record_out #(
        .VAL_W(VAL_W), .FLEN_W(FLEN_W), .SUM_W(SUM_W), .SQ_W(SQ_W),
        .HB_W(HB_W), .SEQ_W(SEQ_W), .OVR_W(OVR_W)
    ) u_rec (
        .clk              (clk),
        .rst              (rst),
        .load             (frame_last),
        .metric_sel       (metric_sel),
        .cnt_in           (cnt_nx),
        .min_in           (min_nx),
        .max_in           (max_nx),
        .sum_in           (sum_nx),
        .sq_in            (sq_nx),
        .len_in           (len_used),
        .hist_in          (bins_nx),
        .outl_in          (outl_nx),
        .rec_ready        (rec_ready),
        .rec_valid        (rec_valid),
        .rec_seq          (rec_seq),
        .rec_len          (rec_len),
        .rec_metric       (rec_metric),
        .rec_sumsq        (rec_sumsq),
        .rec_hist         (rec_hist),
        .rec_outliers     (rec_outliers),
        .rec_outlier_flag (rec_outlier_flag),
        .overrun_cnt      (overrun_cnt)
    );

endmodule

// File: tb/tap_frame_monitor_bench.sv
`timescale 1ns/1ps
module tap_frame_monitor_bench;

    localparam int VAL_W  = 8;
    localparam int FLEN_W = 10;
    localparam int SUM_W  = 12;
    localparam int SQ_W   = 16;
    localparam int HB_W   = 8;
    localparam int SEQ_W  = 8;
    localparam int OVR_W  = 8;
    localparam longint SUM_MAX = (64'd1 << SUM_W) - 1;
    localparam longint SQ_MAX  = (64'd1 << SQ_W) - 1;

    typedef struct {
        int          seq;
        int          len;
        longint      met;
        longint      sq;
        logic [63:0] hist;
        int          outl;
        int          flag;
        string       mtag;
        string       ltag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tap_mode = 1'b0;
    logic              tap_valid = 1'b0;
    logic              tap_ready = 1'b0;
    logic [VAL_W-1:0]  tap_value = '0;
    logic [2:0]        ctx_taps = '0;
    logic [7:0]        ctx_table = '0;
    logic [FLEN_W-1:0] frame_len = FLEN_W'(5);
    logic [1:0]        metric_sel = '0;
    logic [2:0]        hist_base = '0;
    logic [VAL_W-1:0]  outlier_thr = '1;
    logic              rec_ready = 1'b1;
    logic              rec_valid;
    logic [SEQ_W-1:0]  rec_seq;
    logic [FLEN_W-1:0] rec_len;
    logic [SUM_W-1:0]  rec_metric;
    logic [SQ_W-1:0]   rec_sumsq;
    logic [8*HB_W-1:0] rec_hist;
    logic [FLEN_W-1:0] rec_outliers;
    logic              rec_outlier_flag;
    logic [OVR_W-1:0]  overrun_cnt;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   seq_m    = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    tap_frame_monitor #(
        .VAL_W(VAL_W), .FLEN_W(FLEN_W), .SUM_W(SUM_W), .SQ_W(SQ_W),
        .HB_W(HB_W), .SEQ_W(SEQ_W), .OVR_W(OVR_W)
    ) u_tap_frame_monitor (
        .clk(clk), .rst(rst), .tap_mode(tap_mode), .tap_valid(tap_valid),
        .tap_ready(tap_ready), .tap_value(tap_value), .ctx_taps(ctx_taps),
        .ctx_table(ctx_table), .frame_len(frame_len), .metric_sel(metric_sel),
        .hist_base(hist_base), .outlier_thr(outlier_thr), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_seq(rec_seq), .rec_len(rec_len),
        .rec_metric(rec_metric), .rec_sumsq(rec_sumsq), .rec_hist(rec_hist),
        .rec_outliers(rec_outliers), .rec_outlier_flag(rec_outlier_flag),
        .overrun_cnt(overrun_cnt)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int bin_of(input int v, input int base);
        int msb = 0;
        int idx;
        if (v < (1 << base)) return 0;
        for (int i = 0; i < 16; i++) if ((v >> i) & 1) msb = i;
        idx = msb - base + 1;
        return (idx > 7) ? 7 : idx;
    endfunction

    // Drives one frame of len cycles and predicts its record.
    task automatic run_frame(input int len, input int next_len, input int pat,
                             input int mode, input logic [7:0] tt, input int msel,
                             input int base, input int thr, input bit keep,
                             input int rdy_c1, input string mtag, input string ltag,
                             output exp_t e);
        int cnt = 0, mn = 255, mx = 0, outl = 0;
        longint sm = 0, sq = 0;
        int hb[8];
        for (int k = 0; k < 8; k++) hb[k] = 0;
        tap_mode    = mode[0];
        ctx_table   = tt;
        metric_sel  = msel[1:0];
        hist_base   = base[2:0];
        outlier_thr = thr[7:0];
        frame_len   = FLEN_W'(next_len);
        for (int c = 0; c < len; c++) begin
            int  v;
            bit  vld, rdy, fire;
            int  taps;
            if (c == 1 && rdy_c1 >= 0) rec_ready = rdy_c1[0];
            v    = (pat == 99) ? 255 : ((pat * 53 + c * 29 + c * c * 7) & 255);
            vld  = ((c + pat) % 3) != 0;
            rdy  = ((c * pat + 1) % 4) != 0;
            taps = (c * 5 + pat) & 7;
            tap_value = v[7:0];
            tap_valid = vld;
            tap_ready = rdy;
            ctx_taps  = taps[2:0];
            fire = (mode == 1) || (vld && rdy);
            if (tt[taps] && fire) begin
                cnt++;
                if (v < mn) mn = v;
                if (v > mx) mx = v;
                sm += v;
                if (sm > SUM_MAX) sm = SUM_MAX;
                sq += longint'(v) * v;
                if (sq > SQ_MAX) sq = SQ_MAX;
                if (v > thr) outl++;
                hb[bin_of(v, base)]++;
            end
            @(negedge clk);
        end
        e.seq  = seq_m;
        seq_m++;
        e.len  = len;
        case (msel)
            0: e.met = cnt;
            1: e.met = mn;
            2: e.met = mx;
            default: e.met = sm;
        endcase
        e.sq   = sq;
        for (int k = 0; k < 8; k++) e.hist[k*8 +: 8] = hb[k][7:0];
        e.outl = outl;
        e.flag = (outl != 0);
        e.mtag = mtag;
        e.ltag = ltag;
        if (keep) sb.push_back(e);
    endtask

    // Monitor: compares every accepted record with the next expected one.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && rec_valid && rec_ready) begin
                if (sb.size() == 0) begin
                    check("R5", "unexpected record seq", 64'(rec_seq), 64'hFFFF);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R5", "rec_seq", 64'(rec_seq), 64'(e.seq));
                    check(e.ltag, "rec_len", 64'(rec_len), 64'(e.len));
                    check(e.mtag, "rec_metric", 64'(rec_metric), 64'(e.met));
                    check("R7", "rec_sumsq", 64'(rec_sumsq), 64'(e.sq));
                    check("R8", "rec_hist", rec_hist, e.hist);
                    check("R9", "rec_outliers", 64'(rec_outliers), 64'(e.outl));
                    check("R9", "rec_outlier_flag", 64'(rec_outlier_flag), 64'(e.flag));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        exp_t ea, eb, ex;
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        check("R1", "rec_valid in reset", 64'(rec_valid), 64'd0);
        check("R1", "overrun_cnt in reset", 64'(overrun_cnt), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R3: edge mode counting, first length taken in reset
        run_frame(5, 7, 1, 0, 8'hFF, 0, 0, 200, 1, -1, "R3", "R1", ex);
        // R3: level mode sum
        run_frame(7, 6, 2, 1, 8'hFF, 3, 3, 150, 1, -1, "R3", "R4", ex);
        // R2: context t0 AND NOT t1
        run_frame(6, 8, 3, 0, 8'h22, 0, 1, 100, 1, -1, "R2", "R4", ex);
        // R2 / R6: context t1 OR t2, minimum
        run_frame(8, 8, 4, 1, 8'hFC, 1, 4, 50, 1, -1, "R2", "R4", ex);
        // R6: maximum, next length zero
        run_frame(8, 0, 5, 1, 8'hFF, 2, 5, 250, 1, -1, "R6", "R4", ex);
        // R4 / R6: zero length acts as one, empty frame minimum
        run_frame(1, 4, 6, 1, 8'h00, 1, 0, 0, 1, -1, "R6", "R4", ex);
        // R6: empty frame maximum
        run_frame(4, 4, 7, 1, 8'h00, 2, 2, 0, 1, -1, "R6", "R4", ex);
        // R7: square saturates
        run_frame(4, 20, 99, 1, 8'hFF, 3, 7, 254, 1, -1, "R7", "R4", ex);
        // R7: sum saturates
        run_frame(20, 10, 99, 1, 8'hFF, 3, 6, 0, 1, -1, "R7", "R4", ex);
        // R8 / R9: histogram spread and outliers
        run_frame(10, 10, 8, 1, 8'hFF, 2, 2, 100, 1, -1, "R9", "R4", ex);

        // R10: drop ready, let two frames close
        run_frame(10, 10, 9, 1, 8'hFF, 0, 1, 90, 0, 0, "R10", "R4", ea);
        #1;
        check("R10", "pending rec_valid", 64'(rec_valid), 64'd1);
        check("R10", "pending rec_seq", 64'(rec_seq), 64'(ea.seq));
        run_frame(10, 10, 10, 0, 8'hFF, 3, 2, 120, 1, -1, "R10", "R4", eb);
        rec_ready = 1'b1;
        #1;
        check("R10", "overrun_cnt after replace", 64'(overrun_cnt), 64'd1);
        check("R10", "replaced rec_seq", 64'(rec_seq), 64'(eb.seq));
        run_frame(10, 5, 11, 1, 8'h0F, 2, 3, 60, 1, -1, "R2", "R4", ex);
        run_frame(5, 5, 12, 0, 8'hF0, 0, 0, 10, 1, -1, "R3", "R4", ex);

        repeat (3) @(negedge clk);
        #1;
        check("R5", "all records delivered", 64'(sb.size()), 64'd0);
        check("R10", "overrun_cnt final", 64'(overrun_cnt), 64'd1);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule